// File: doc/BRIEF.md
# Clock Path Router and Divider Bank

This block sits between a reference clock, an external analog frequency multiplier and the clock consumers of a chip. A programmable pre-divider scales the reference clock down and drives the multiplier's input. A programmable post-divider scales the multiplier's output down. A mode bit then chooses the source for a bank of programmable system clock dividers. That source is either the post-divided multiplied clock or the reference clock itself, which is the bypass path. Two further outputs have fixed ratios. The first is the reference clock divided by eight. The second is the selected source passed through at divide-by-one.

Software programs the block through a write-only register port clocked by the reference clock. Every divider has its own enable bit and ratio field. A disabled divider drives its output low. The block leaves reset in bypass mode with every programmable divider turned off. A request for the multiplied path is refused while the pre-divider or the post-divider is disabled. A refused request raises an error flag, and the block stays in bypass.

Top module: `clkpath_ctrl`

## Requirements
- R1: With the mode bit at 1, the system source is clk_mult divided by (post ratio + 1), and clk_mult_ref is clk_ref divided by (pre ratio + 1).
- R2: With the mode bit at 0, the system source is clk_ref itself.
- R3: After reset, the mode is bypass, cfg_err is 0, and the pre, post and system dividers are all disabled.
- R4: While a divider is disabled, its output stays low and never toggles.
- R5: Register writes use the following layout. Address 0 bit 0 is the mode bit. Address 1 is the pre-divider, address 2 is the post-divider, and address 3+k is system divider k. In each divider word, bit RATIO_W is the enable and bits RATIO_W-1:0 hold the ratio field. An enabled divider divides by (field + 1).
- R6: A write of mode 1 takes effect only if both the pre and post enables are set. Otherwise the mode stays 0 and cfg_err is set. Any accepted mode write clears cfg_err.
- R7: Every divider output has a 50% duty cycle for odd ratios, even ratios and divide-by-one.
- R8: clk_bp is always clk_ref divided by 8. sysclk1 is the current system source divided by 1.
- R9: A new ratio or enable is taken up only at an output period boundary, so no pulse is shorter than the high time of the old ratio or of the new ratio.
- R10: Clearing the pre or post enable while in the multiplied mode drops the block to bypass and sets cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the register port |
| clk_mult | input | 1 | Output of the external multiplier |
| rst_n | input | 1 | Synchronous active-low reset, held across several cycles of every clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | RATIO_W+1 | Write data: enable in the top bit, ratio field below it |
| clk_mult_ref | output | 1 | Pre-divided reference clock, fed to the multiplier |
| clk_bp | output | 1 | Reference clock divided by 8 |
| sysclk1 | output | 1 | System source divided by 1 |
| sysclk | output | N_SYS | Programmable system clock outputs |
| cfg_err | output | 1 | Set when a mode setting is refused or forced back to bypass |

## Verification
The bench builds the block with its defaults: three system dividers and a 5-bit ratio field. This puts divide-by-one, small even ratios, small odd ratios and the fixed divide-by-8 output all within reach of short runs. The reference clock runs at a 4 ns period and the multiplier clock at 3 ns. Because the post-divider uses an odd ratio, the system source has a 9 ns period, so odd division of an already odd-divided source is exercised. The bench measures the high time and the period of every output it checks. It also inspects the pulses that follow a ratio change, which would expose a runt pulse.

// File: rtl/clkpath_pkg.sv
// Package: register address map shared by the register port and the bench.
package clkpath_pkg;
    localparam int ADDR_MODE = 0;   // bit 0: multiplied-path select
    localparam int ADDR_PRE  = 1;   // pre-divider word
    localparam int ADDR_POST = 2;   // post-divider word
    localparam int ADDR_SYS0 = 3;   // first programmable system divider
endpackage

// File: rtl/clk_divider.sv
// Module: clk_divider
// Divides clk_in by (ratio + 1) with a 50% duty cycle. Enable and ratio are
// sampled into a shadow copy only at a period boundary, or while the divider
// is idle. Odd ratios AND the rising-edge phase with a copy retimed on the
// falling edge. Divide-by-one gates the input clock behaviourally.
// Assumes en/ratio are quasi-static relative to clk_in, and that rst_n is held
// for several clk_in cycles.
module clk_divider #(
    parameter int RATIO_W = 5
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out
);
    logic               active;
    logic [RATIO_W-1:0] n_m1;
    logic [RATIO_W-1:0] cnt;
    logic               q_pos;
    logic               q_neg;
    logic [RATIO_W:0]   cnt_nx;
    logic [RATIO_W:0]   half;
    logic               boundary;
    logic               odd_div;

    // Next count, length of the high phase, and the boundary condition.
    always_comb begin
        cnt_nx   = {1'b0, cnt} + (RATIO_W+1)'(1);
        half     = ({1'b0, n_m1} + (RATIO_W+1)'(2)) >> 1;
        boundary = !active || (cnt == n_m1);
        odd_div  = !n_m1[0];
    end

    // Rising-edge counter: shadow load at boundaries, high phase otherwise.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            active <= 1'b0;
            n_m1   <= '0;
            cnt    <= '0;
            q_pos  <= 1'b0;
        end else if (boundary) begin
            active <= en;
            n_m1   <= ratio;
            cnt    <= '0;
            q_pos  <= en;
        end else begin
            cnt    <= cnt_nx[RATIO_W-1:0];
            q_pos  <= (cnt_nx < half);
        end
    end

    // Half-cycle retimed copy of the high phase, used for odd ratios.
    always_ff @(negedge clk_in) begin
        if (!rst_n) q_neg <= 1'b0;
        else        q_neg <= q_pos;
    end

    // Output select: pass-through, odd combine, or plain even phase.
    always_comb begin
        if (n_m1 == '0)   clk_out = clk_in & active;
        else if (odd_div) clk_out = q_pos & q_neg;
        else              clk_out = q_pos;
    end

    p_cnt_bound_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        cnt <= n_m1);
    p_off_low_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        !active |-> !q_pos);
    p_load_at_edge_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        (n_m1 != $past(n_m1)) |-> $past(!active || cnt == n_m1));
endmodule

// File: rtl/clkpath_regs.sv
// Module: clkpath_regs
// Write-only configuration port in the clk_ref domain. Holds the mode bit,
// the pre/post divider words and the system divider words. It refuses the
// multiplied mode unless both path dividers are enabled.
// Assumes a single write per strobe cycle.
module clkpath_regs
    import clkpath_pkg::*;
#(
    parameter int N_SYS   = 3,
    parameter int RATIO_W = 5,
    parameter int ADDR_W  = 3,
    localparam int DW     = RATIO_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DW-1:0]             wdata,
    output logic                      mode_pll,
    output logic                      cfg_err,
    output logic [DW-1:0]             pre_cfg,
    output logic [DW-1:0]             post_cfg,
    output logic [N_SYS-1:0][DW-1:0]  sys_cfg
);
    // Register writes with the mode-consistency rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pll <= 1'b0;
            cfg_err  <= 1'b0;
            pre_cfg  <= '0;
            post_cfg <= '0;
            sys_cfg  <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_MODE)) begin
                if (wdata[0] && !(pre_cfg[RATIO_W] && post_cfg[RATIO_W])) begin
                    mode_pll <= 1'b0;
                    cfg_err  <= 1'b1;
                end else begin
                    mode_pll <= wdata[0];
                    cfg_err  <= 1'b0;
                end
            end else if (addr == ADDR_W'(ADDR_PRE)) begin
                pre_cfg <= wdata;
                if (mode_pll && !wdata[RATIO_W]) begin
                    mode_pll <= 1'b0;
                    cfg_err  <= 1'b1;
                end
            end else if (addr == ADDR_W'(ADDR_POST)) begin
                post_cfg <= wdata;
                if (mode_pll && !wdata[RATIO_W]) begin
                    mode_pll <= 1'b0;
                    cfg_err  <= 1'b1;
                end
            end else begin
                for (int k = 0; k < N_SYS; k++) begin
                    if (addr == ADDR_W'(ADDR_SYS0 + k)) sys_cfg[k] <= wdata;
                end
            end
        end
    end

    p_pll_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pll |-> (pre_cfg[RATIO_W] && post_cfg[RATIO_W]));
    p_err_in_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !mode_pll);
    p_reset_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mode_pll && !cfg_err));
endmodule

// File: rtl/clk_src_sel.sv
// Module: clk_src_sel
// Behavioural clock source select: multiplied path when sel is 1, otherwise
// the reference. Assumes a glitch-free cell replaces it in implementation.
module clk_src_sel (
    input  logic sel,
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_o
);
    // Two-way clock mux.
    always_comb clk_o = sel ? clk_a : clk_b;
endmodule

// File: rtl/clkpath_ctrl.sv
// Module: clkpath_ctrl
// Clock path top: pre-divider to the multiplier, post-divider from it, a
// mode-selected system source, and a bank of system dividers plus two fixed
// outputs. Assumes rst_n spans several cycles of clk_ref and clk_mult.
module clkpath_ctrl #(
    parameter int N_SYS   = 3,
    parameter int RATIO_W = 5,
    localparam int ADDR_W = $clog2(3 + N_SYS),
    localparam int DW     = RATIO_W + 1
) (
    input  logic              clk_ref,
    input  logic              clk_mult,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              clk_mult_ref,
    output logic              clk_bp,
    output logic              sysclk1,
    output logic [N_SYS-1:0]  sysclk,
    output logic              cfg_err
);
    logic                     mode_pll;
    logic [DW-1:0]            pre_cfg;
    logic [DW-1:0]            post_cfg;
    logic [N_SYS-1:0][DW-1:0] sys_cfg;
    logic                     post_clk;
    logic                     sys_src;

    clkpath_regs #(.N_SYS(N_SYS), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk_ref), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .mode_pll(mode_pll), .cfg_err(cfg_err),
        .pre_cfg(pre_cfg), .post_cfg(post_cfg), .sys_cfg(sys_cfg)
    );

    clk_divider #(.RATIO_W(RATIO_W)) u_pre (
        .clk_in(clk_ref), .rst_n(rst_n), .en(pre_cfg[RATIO_W]),
        .ratio(pre_cfg[RATIO_W-1:0]), .clk_out(clk_mult_ref)
    );

    clk_divider #(.RATIO_W(RATIO_W)) u_post (
        .clk_in(clk_mult), .rst_n(rst_n), .en(post_cfg[RATIO_W]),
        .ratio(post_cfg[RATIO_W-1:0]), .clk_out(post_clk)
    );

    clk_src_sel u_sel (
        .sel(mode_pll), .clk_a(post_clk), .clk_b(clk_ref), .clk_o(sys_src)
    );

    clk_divider #(.RATIO_W(RATIO_W)) u_bp (
        .clk_in(clk_ref), .rst_n(rst_n), .en(1'b1),
        .ratio(RATIO_W'(7)), .clk_out(clk_bp)
    );

    clk_divider #(.RATIO_W(RATIO_W)) u_sys1 (
        .clk_in(sys_src), .rst_n(rst_n), .en(1'b1),
        .ratio('0), .clk_out(sysclk1)
    );

    for (genvar k = 0; k < N_SYS; k++) begin : g_sys
        clk_divider #(.RATIO_W(RATIO_W)) u_div (
            .clk_in(sys_src), .rst_n(rst_n), .en(sys_cfg[k][RATIO_W]),
            .ratio(sys_cfg[k][RATIO_W-1:0]), .clk_out(sysclk[k])
        );
    end
endmodule

// File: tb/sim_clkpath_ctrl.sv
`timescale 1ns/1ps
module sim_clkpath_ctrl;
    import clkpath_pkg::*;
    localparam int N_SYS = 3;
    localparam int RW    = 5;
    localparam int AW    = $clog2(3 + N_SYS);

    typedef struct {
        int      sel;    // 0..2 sysclk, 3 sysclk1, 4 clk_bp, 5 clk_mult_ref
        int      kind;   // 0 measure, 1 silent, 2 transition
        realtime per;
        realtime hi;
        realtime alt;
        string   req;
    } exp_t;

    logic clk_ref = 0, clk_mult = 0, rst_n = 0, reg_we = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW:0]   reg_wdata = '0;
    logic clk_mult_ref, clk_bp, sysclk1, cfg_err;
    logic [N_SYS-1:0] sysclk;
    int checks = 0, fails = 0, pending = 0, edges = 0, sel = 0;
    exp_t q[$];
    logic [5:0] all_clk;
    logic mon_clk;

    always #2   clk_ref  = ~clk_ref;
    always #1.5 clk_mult = ~clk_mult;

    clkpath_ctrl #(.N_SYS(N_SYS), .RATIO_W(RW)) u0 (
        .clk_ref(clk_ref), .clk_mult(clk_mult), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .clk_mult_ref(clk_mult_ref), .clk_bp(clk_bp), .sysclk1(sysclk1),
        .sysclk(sysclk), .cfg_err(cfg_err)
    );

    assign all_clk = {clk_mult_ref, clk_bp, sysclk1, sysclk};
    assign mon_clk = all_clk[sel];
    always @(posedge mon_clk) edges++;

    function automatic bit near(realtime a, realtime b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    task automatic note(bit ok, string req, string what, realtime act, realtime expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, expv);
        end
    endtask

    task automatic wr(int addr, bit en, int ratio);
        @(negedge clk_ref);
        reg_we = 1; reg_addr = AW'(addr); reg_wdata = {en, RW'(ratio)};
        @(negedge clk_ref);
        reg_we = 0;
    endtask

    task automatic expect_clk(int s, int kind, realtime per, realtime hi, realtime alt, string req);
        exp_t e;
        e.sel = s; e.kind = kind; e.per = per; e.hi = hi; e.alt = alt; e.req = req;
        q.push_back(e);
        pending++;
        wait (pending == 0);
    endtask

    task automatic chk_err(bit expv, string req);
        @(negedge clk_ref);
        note(cfg_err == expv, req, "cfg_err", cfg_err, expv);
    endtask

    // Monitor: pops expected items and measures the selected output.
    initial begin
        forever begin
            exp_t e;
            realtime t0, t1, t2;
            wait (pending > 0);
            e = q.pop_front();
            sel = e.sel;
            if (e.kind == 0) begin
                repeat (3) @(posedge mon_clk);
                t0 = $realtime; @(negedge mon_clk);
                t1 = $realtime; @(posedge mon_clk);
                t2 = $realtime;
                note(near(t2 - t0, e.per), e.req, "period", t2 - t0, e.per);
                note(near(t1 - t0, e.hi), e.req, "high time", t1 - t0, e.hi);
            end else if (e.kind == 1) begin
                int e0;
                #100;
                e0 = edges;
                #300;
                note(edges == e0 && mon_clk == 1'b0, e.req, "edges while off",
                     edges - e0, 0);
            end else begin
                for (int i = 0; i < 3; i++) begin
                    @(posedge mon_clk); t0 = $realtime;
                    @(negedge mon_clk); t1 = $realtime;
                    note(near(t1 - t0, e.hi) || near(t1 - t0, e.alt), e.req,
                         "pulse during ratio change", t1 - t0, e.alt);
                end
            end
            pending--;
        end
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Driver: stimulus sequence with expected results pushed to the scoreboard.
    initial begin
        repeat (10) @(negedge clk_ref);
        rst_n = 1;
        chk_err(0, "R3");
        expect_clk(3, 0, 4, 2, 0, "R2");            // bypass: sysclk1 = ref
        expect_clk(4, 0, 32, 16, 0, "R8");          // fixed /8
        for (int k = 0; k < N_SYS; k++) expect_clk(k, 1, 0, 0, 0, "R3");
        expect_clk(5, 1, 0, 0, 0, "R4");            // pre-divider off
        wr(ADDR_SYS0 + 0, 1, 3);
        expect_clk(0, 0, 16, 8, 0, "R5");
        wr(ADDR_SYS0 + 1, 1, 4);
        expect_clk(1, 0, 20, 10, 0, "R7");
        wr(ADDR_SYS0 + 2, 1, 0);
        expect_clk(2, 0, 4, 2, 0, "R7");
        wr(ADDR_MODE, 1, 1);                        // refused: path dividers off
        chk_err(1, "R6");
        expect_clk(3, 0, 4, 2, 0, "R6");
        wr(ADDR_PRE, 1, 1);
        expect_clk(5, 0, 8, 4, 0, "R1");
        wr(ADDR_POST, 1, 2);
        wr(ADDR_MODE, 1, 1);
        chk_err(0, "R6");
        expect_clk(3, 0, 9, 4.5, 0, "R1");
        expect_clk(0, 0, 36, 18, 0, "R1");
        expect_clk(1, 0, 45, 22.5, 0, "R7");
        wr(ADDR_SYS0 + 0, 1, 5);
        expect_clk(0, 2, 0, 18, 27, "R9");
        expect_clk(0, 0, 54, 27, 0, "R5");
        wr(ADDR_SYS0 + 0, 0, 5);
        expect_clk(0, 1, 0, 0, 0, "R4");
        wr(ADDR_PRE, 0, 1);
        chk_err(1, "R10");
        expect_clk(3, 0, 4, 2, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule